// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Bus Handshake

This block moves a block of words between an I/O device port and a memory port so that the CPU does not have to copy each word itself. The CPU first writes a start address and a word count, and then writes a control word that gives the direction and the bus-holding mode. That control write starts the transfer. From then on the engine waits for the device to report that it is ready. It then raises a bus request and touches the bus only after a grant arrives. For each word it drives the memory address and the matching read and write strobes. In the same cycle the data passes straight from source to sink.

After every word the address goes up by one and the remaining count goes down by one. When the last word has moved, the engine drops its request, clears its busy flag and raises an interrupt. The interrupt stays high until the CPU clears it. Three modes set how long the bus is held:
- **Block-hold** keeps the request up for the whole block.
- **Single-word steal** gives the bus back after every word.
- **Idle-slot** moves a word only in cycles when the CPU reports that it is not using the bus.

Top module: `dma_block_mover`

## Requirements
- R1: After reset, bus_req, irq and all four strobes are low, and the status read (selector 3) returns busy bit 0 = 0 and interrupt bit 1 = 0.
- R2: Register selectors are 0 = start/current address, 1 = word count, 2 = control (bit 0 direction, bits 2:1 mode; a write starts a transfer), 3 = status (read: bit 0 busy, bit 1 interrupt; write with bit 0 = 1 clears the interrupt). Busy reads 1 from a start with a nonzero count until the last word. While busy, writes to selectors 0, 1 and 2 are ignored.
- R3: No strobe is asserted and mem_addr stays zero unless bus_req and bus_gnt are both high in that cycle. The request is raised only after dev_ready has been seen while busy.
- R4: Each moved word uses the current address. After the word, the address read back is one higher and the count is one lower.
- R5: In the cycle after the last word, bus_req and busy are low and irq is high.
- R6: Mode 0 (block-hold): once raised, bus_req stays high until the last word has moved, even while dev_ready or bus_gnt is low.
- R7: Mode 1 (single-word steal): bus_req is low in the cycle after every moved word. It rises again on the next cycle with dev_ready.
- R8: Mode 2 (idle-slot): no word moves in a cycle where cpu_busy is high.
- R9: If bus_gnt is withdrawn during a block, no strobe is asserted, the address and count are held, and the block resumes when the grant returns.
- R10: A start with a count of zero raises irq on the next cycle, leaves busy low and never raises bus_req.
- R11: Once raised, irq stays high until a status write with bit 0 = 1. If a completion and a clear fall in the same cycle, the completion wins.
- R12: Direction bit 0 = 0 moves device to memory (dev_rd and mem_wr, with mem_wdata = dev_rdata). Direction bit 0 = 1 moves memory to device (mem_rd and dev_wr, with dev_wdata = mem_rdata).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for cfg_sel |
| dev_ready | input | 1 | Device can move a word |
| dev_rdata | input | DW | Data from device |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | DW | Data to device |
| mem_addr | output | AW | Memory address while a word moves |
| mem_rdata | input | DW | Memory read data (same cycle) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| cpu_busy | input | 1 | CPU is using the bus |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume three things about the inputs:
- Register writes are single-cycle pulses with one selector.
- The memory and device ports answer in the same cycle.
- cpu_busy only matters in idle-slot mode.

They do not assume that the grant follows the request, so a grant that arrives early or that is withdrawn must still never produce a strobe. The stimulus keeps every configuration write away from the cycles of an active block, except in the deliberate ignored-write case. It drives the grant either as an echo of the request or from a hand-written pattern that drops it partway through a block.

// File: rtl/dma_block_mover_pkg.sv
package dma_block_mover_pkg;

  typedef enum logic [1:0] {
    MODE_BURST   = 2'd0,
    MODE_STEAL   = 2'd1,
    MODE_IDLEBUS = 2'd2,
    MODE_RSVD    = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STAT  = 2'd3
  } cfg_sel_e;

  localparam int CTRL_DIR_BIT  = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IRQ_BIT  = 1;
  localparam int STAT_CLR_BIT  = 0;

  typedef struct packed {
    logic       mem_to_dev;
    xfer_mode_e mode;
  } xfer_cfg_t;

endpackage

// File: rtl/dma_block_mover_regs.sv
module dma_block_mover_regs
  import dma_block_mover_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          word_done,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output xfer_cfg_t     cfg_o,
  output logic          busy,
  output logic          irq,
  output logic          last_word
);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  xfer_cfg_t     cfg_q;
  logic          busy_q, irq_q;
  logic          wr_addr, wr_cnt, start_ev, zero_start, done_ev, clr_ev;

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a_in);
    return a_in + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_after(input logic [CW-1:0] c_in);
    return c_in - CW'(1);
  endfunction

  // configuration decode: address, count and control are locked while busy
  assign wr_addr    = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_ADDR)  && !busy_q;
  assign wr_cnt     = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_COUNT) && !busy_q;
  assign start_ev   = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_CTRL)  && !busy_q;
  assign clr_ev     = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_STAT)  && cfg_wdata[STAT_CLR_BIT];
  assign zero_start = start_ev && (cnt_q == '0);
  assign last_word  = (cnt_q == CW'(1));
  assign done_ev    = word_done && last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      cfg_q  <= '{mem_to_dev: 1'b0, mode: MODE_BURST};
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_addr)        addr_q <= cfg_wdata[AW-1:0];
      else if (word_done) addr_q <= addr_after(addr_q);

      if (wr_cnt)         cnt_q <= cfg_wdata[CW-1:0];
      else if (word_done) cnt_q <= cnt_after(cnt_q);

      if (start_ev) begin
        cfg_q.mem_to_dev <= cfg_wdata[CTRL_DIR_BIT];
        cfg_q.mode       <= xfer_mode_e'(cfg_wdata[CTRL_MODE_LSB +: 2]);
      end

      if (start_ev && !zero_start) busy_q <= 1'b1;
      else if (done_ev)            busy_q <= 1'b0;

      // completion wins over a clear in the same cycle
      if (done_ev || zero_start) irq_q <= 1'b1;
      else if (clr_ev)           irq_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel_e'(cfg_sel))
      SEL_ADDR:  cfg_rdata[AW-1:0] = addr_q;
      SEL_COUNT: cfg_rdata[CW-1:0] = cnt_q;
      SEL_CTRL: begin
        cfg_rdata[CTRL_DIR_BIT]           = cfg_q.mem_to_dev;
        cfg_rdata[CTRL_MODE_LSB +: 2]     = cfg_q.mode;
      end
      default: begin
        cfg_rdata[STAT_BUSY_BIT] = busy_q;
        cfg_rdata[STAT_IRQ_BIT]  = irq_q;
      end
    endcase
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign cfg_o    = cfg_q;
  assign busy     = busy_q;
  assign irq      = irq_q;

  // R10: zero-length start completes without ever becoming busy
  a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> irq_q && !busy_q);

  // R11: interrupt persists until a clear
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr_ev |=> irq_q);

  // R2: a busy block ignores control writes
  a_r2_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_CTRL) |=> $stable(cfg_q));

endmodule

// File: rtl/dma_block_mover_arb.sv
module dma_block_mover_arb
  import dma_block_mover_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  xfer_mode_e mode,
  input  logic       last_word,
  input  logic       dev_ready,
  input  logic       bus_gnt,
  input  logic       cpu_busy,
  output logic       bus_req,
  output logic       word_fire
);

  logic req_q, req_d, cpu_blocks;

  function automatic logic next_req(input logic active, input logic held,
                                    input logic moved, input logic final_w,
                                    input logic rdy, input xfer_mode_e m);
    if (!active)                   return 1'b0;
    if (moved && final_w)          return 1'b0;
    if (m == MODE_STEAL && moved)  return 1'b0;
    return held | rdy;
  endfunction

  assign cpu_blocks = (mode == MODE_IDLEBUS) && cpu_busy;
  assign word_fire  = busy && req_q && bus_gnt && dev_ready && !cpu_blocks;
  assign req_d      = next_req(busy, req_q, word_fire, last_word, dev_ready, mode);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign bus_req = req_q;

  // R6: block-hold keeps the request until the final word
  a_r6_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode == MODE_BURST && req_q && !(word_fire && last_word) |=> req_q);

  // R7: single-word steal releases the bus after each word
  a_r7_steal_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_STEAL && word_fire |=> !req_q);

  // R8: idle-slot mode yields to the CPU
  a_r8_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_IDLEBUS && cpu_busy |-> !word_fire);

endmodule

// File: rtl/dma_block_mover_path.sv
module dma_block_mover_path #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_fire,
  input  logic          mem_to_dev,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] dev_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata
);

  logic to_mem, to_dev;

  assign to_mem    = word_fire && !mem_to_dev;
  assign to_dev    = word_fire &&  mem_to_dev;
  assign mem_addr  = word_fire ? cur_addr : '0;
  assign dev_rd    = to_mem;
  assign mem_wr    = to_mem;
  assign mem_rd    = to_dev;
  assign dev_wr    = to_dev;
  assign mem_wdata = to_mem ? dev_rdata : '0;
  assign dev_wdata = to_dev ? mem_rdata : '0;

  // R12: one direction per word, source and sink strobes paired
  a_r12_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && (dev_rd == mem_wr) && (dev_wr == mem_rd));

endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover
  import dma_block_mover_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          cpu_busy,
  output logic          irq
);

  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt;
  xfer_cfg_t     xcfg;
  logic          busy, last_word, word_fire, strobe;

  dma_block_mover_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .word_done(word_fire),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .cfg_o(xcfg), .busy(busy),
    .irq(irq), .last_word(last_word)
  );

  dma_block_mover_arb u_arb (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mode(xcfg.mode),
    .last_word(last_word), .dev_ready(dev_ready), .bus_gnt(bus_gnt),
    .cpu_busy(cpu_busy), .bus_req(bus_req), .word_fire(word_fire)
  );

  dma_block_mover_path #(.AW(AW), .DW(DW)) u_path (
    .clk(clk), .rst_n(rst_n), .word_fire(word_fire),
    .mem_to_dev(xcfg.mem_to_dev), .cur_addr(cur_addr),
    .dev_rdata(dev_rdata), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata)
  );

  assign strobe = mem_rd | mem_wr;

  // R3: the bus is touched only under request and grant
  a_r3_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe || dev_rd || dev_wr) |-> bus_req && bus_gnt);

  // R3: no request without an active block
  a_r3_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  // R4: address advances past the word just moved
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !last_word |=> cur_addr == $past(mem_addr) + AW'(1));

  // R5: the final word releases the bus and interrupts
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && last_word |=> !bus_req && irq && !busy);

  // R9: without a grant, position in the block is frozen
  a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_gnt |=> $stable(cur_addr) && $stable(cur_cnt));

endmodule

// File: tb/dma_block_mover_test.sv
module dma_block_mover_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [15:0] cfg_wdata = '0;
  logic        dev_ready = 1'b0;
  logic        bus_gnt = 1'b0;
  logic        cpu_busy = 1'b0;
  logic [15:0] cfg_rdata, dev_wdata, mem_wdata, dev_rdata, mem_rdata, mem_addr;
  logic        dev_rd, dev_wr, mem_rd, mem_wr, bus_req, irq;

  logic [15:0] mem [256];
  logic [15:0] dev_got [$];
  int          dev_rd_cnt = 0;
  bit          auto_gnt = 1'b1;
  logic [15:0] rd_seen;

  // behavioural reference state
  bit m_busy, m_irq, m_req, m_dir;
  int m_mode, m_addr, m_cnt;

  int  checks = 0, fails = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdata = 16'hA000 + 16'(dev_rd_cnt);

  dma_block_mover uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_ready(dev_ready),
    .dev_rdata(dev_rdata), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .dev_wdata(dev_wdata), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .cpu_busy(cpu_busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: settle, compare against the reference, advance both
  task automatic tick();
    bit mv, nreq, c_mwr, c_drd, c_dwr;
    logic [15:0] c_addr, c_mwd, c_dwd;
    logic [3:0] exp_vec;
    if (auto_gnt) bus_gnt = bus_req;
    #1;
    rd_seen = cfg_rdata;
    mv = m_busy && m_req && bus_gnt && dev_ready && !(m_mode == 2 && cpu_busy);
    chk(bus_req == m_req, m_mode == 1 ? "R7 request" : (m_mode == 2 ? "R8 request" : "R6 request"),
        bus_req, m_req);
    chk((mem_rd | mem_wr | dev_rd | dev_wr) == mv, "R3 strobes",
        {mem_rd, mem_wr, dev_rd, dev_wr}, mv);
    if (mv) begin
      chk(mem_addr == 16'(m_addr), "R4 address", mem_addr, m_addr);
      exp_vec = m_dir ? 4'b1001 : 4'b0110;
      chk({mem_rd, mem_wr, dev_rd, dev_wr} == exp_vec, "R12 direction",
          {mem_rd, mem_wr, dev_rd, dev_wr}, exp_vec);
    end
    chk(irq == m_irq, "R11 interrupt", irq, m_irq);
    if (cfg_sel == 2'd3 && !cfg_wr)
      chk(cfg_rdata[1:0] == {m_irq, m_busy}, "R2 status", cfg_rdata[1:0], {m_irq, m_busy});
    if (!m_busy)                 nreq = 1'b0;
    else if (mv && m_cnt == 1)   nreq = 1'b0;
    else if (m_mode == 1 && mv)  nreq = 1'b0;
    else                         nreq = m_req || dev_ready;
    c_mwr = mem_wr; c_drd = dev_rd; c_dwr = dev_wr;
    c_addr = mem_addr; c_mwd = mem_wdata; c_dwd = dev_wdata;
    @(posedge clk);
    if (c_mwr) mem[c_addr[7:0]] = c_mwd;
    if (c_drd) dev_rd_cnt++;
    if (c_dwr) dev_got.push_back(c_dwd);
    m_req = nreq;
    if (cfg_wr) begin
      case (cfg_sel)
        2'd0: if (!m_busy) m_addr = int'(cfg_wdata);
        2'd1: if (!m_busy) m_cnt = int'(cfg_wdata) & 'hFFF;
        2'd2: if (!m_busy) begin
          m_dir  = cfg_wdata[0];
          m_mode = (cfg_wdata[2:1] == 2'd3) ? 0 : int'(cfg_wdata[2:1]);
          if (m_cnt == 0) m_irq = 1'b1; else m_busy = 1'b1;
        end
        default: if (cfg_wdata[0]) m_irq = 1'b0;
      endcase
    end
    if (mv) begin
      m_addr = (m_addr + 1) & 'hFFFF;
      m_cnt--;
      if (m_cnt == 0) begin m_busy = 1'b0; m_irq = 1'b1; end
    end
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
    tick();
    cfg_wr = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [15:0] val);
    cfg_sel = sel;
    tick();
    val = rd_seen;
    cfg_sel = 2'd3;
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq; i++) tick();
  endtask

  task automatic start(input int base, input int cnt, input logic [15:0] ctrl);
    cfg_write(2'd3, 16'h1);
    cfg_write(2'd0, 16'(base));
    cfg_write(2'd1, 16'(cnt));
    cfg_write(2'd2, ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, held_cnt, held_addr;
    int seq0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h5000 + 16'(i);

    // R1 reset state
    repeat (2) @(negedge clk);
    #1;
    chk(!bus_req && !irq, "R1 reset req/irq", {bus_req, irq}, 0);
    chk(!(mem_rd | mem_wr | dev_rd | dev_wr), "R1 reset strobes", {mem_rd, mem_wr, dev_rd, dev_wr}, 0);
    chk(cfg_rdata[1:0] == 2'b00, "R1 reset status", cfg_rdata[1:0], 0);
    rst_n = 1'b1;
    @(negedge clk);

    // block-hold, device to memory
    dev_ready = 1'b1;
    seq0 = dev_rd_cnt;
    start(16'h10, 5, 16'h0000);
    wait_irq(40);
    for (int i = 0; i < 5; i++)
      chk(mem[16'h10 + i] == 16'hA000 + 16'(seq0 + i), "R12 device to memory data",
          mem[16'h10 + i], 16'hA000 + 16'(seq0 + i));
    chk(!bus_req && irq, "R5 release after last word", {bus_req, irq}, 2'b01);
    peek(2'd3, v);
    chk(v[0] == 1'b0, "R5 busy cleared", v[0], 0);
    repeat (3) tick();
    chk(irq == 1'b1, "R11 irq held without clear", irq, 1);
    cfg_write(2'd3, 16'h1);
    chk(irq == 1'b0, "R11 irq cleared", irq, 0);

    // single-word steal, memory to device
    dev_got.delete();
    start(16'h10, 4, 16'h0003);
    wait_irq(40);
    chk(dev_got.size() == 4, "R7 word count", dev_got.size(), 4);
    for (int i = 0; i < 4 && i < dev_got.size(); i++)
      chk(dev_got[i] == mem[16'h10 + i], "R12 memory to device data", dev_got[i], mem[16'h10 + i]);

    // idle-slot with a busy CPU two cycles out of three
    seq0 = dev_rd_cnt;
    start(16'h40, 6, 16'h0004);
    for (int k = 0; k < 80 && !irq; k++) begin
      cpu_busy = (k % 3 != 2);
      tick();
    end
    cpu_busy = 1'b0;
    for (int i = 0; i < 6; i++)
      chk(mem[16'h40 + i] == 16'hA000 + 16'(seq0 + i), "R8 idle-slot data",
          mem[16'h40 + i], 16'hA000 + 16'(seq0 + i));

    // grant withdrawn in the middle of a block
    auto_gnt = 1'b0;
    bus_gnt = 1'b0;
    seq0 = dev_rd_cnt;
    start(16'h60, 6, 16'h0000);
    tick();
    bus_gnt = 1'b1;
    repeat (2) tick();
    bus_gnt = 1'b0;
    peek(2'd1, held_cnt);
    peek(2'd0, held_addr);
    repeat (3) tick();
    peek(2'd1, v);
    chk(v == held_cnt, "R9 count held", v, held_cnt);
    chk(held_cnt == 16'd4, "R9 words before withdrawal", held_cnt, 4);
    peek(2'd0, v);
    chk(v == held_addr, "R9 address held", v, held_addr);
    chk(v == 16'h62, "R4 address stepped", v, 16'h62);
    bus_gnt = 1'b1;
    wait_irq(40);
    auto_gnt = 1'b1;
    for (int i = 0; i < 6; i++)
      chk(mem[16'h60 + i] == 16'hA000 + 16'(seq0 + i), "R9 resumed data",
          mem[16'h60 + i], 16'hA000 + 16'(seq0 + i));

    // zero count
    start(16'h70, 0, 16'h0000);
    chk(irq == 1'b1, "R10 immediate interrupt", irq, 1);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(!bus_req, "R10 no request", bus_req, 0);
    end
    peek(2'd3, v);
    chk(v[0] == 1'b0, "R10 never busy", v[0], 0);

    // writes while busy are ignored
    dev_ready = 1'b0;
    start(16'h80, 3, 16'h0000);
    cfg_write(2'd0, 16'h99);
    cfg_write(2'd1, 16'd7);
    cfg_write(2'd2, 16'h0003);
    peek(2'd0, v);
    chk(v == 16'h80, "R2 address write ignored", v, 16'h80);
    peek(2'd1, v);
    chk(v == 16'd3, "R2 count write ignored", v, 3);
    peek(2'd2, v);
    chk(v[2:0] == 3'b000, "R2 control write ignored", v[2:0], 0);
    peek(2'd3, v);
    chk(v[0] == 1'b1, "R2 busy while pending", v[0], 1);
    dev_ready = 1'b1;
    wait_irq(40);
    chk(mem[16'h83] == 16'h5083, "R2 block length kept", mem[16'h83], 16'h5083);
    chk(mem[16'h99] == 16'h5099, "R2 address kept", mem[16'h99], 16'h5099);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule